// File: doc/BRIEF.md
# Type-0 PCI Configuration Address Translator

This block sits behind the CPU window that reaches configuration space on the secondary PCI bus. For each request it forms a 32-bit configuration word. The upper half of that word comes from a mapping register and the lower half comes from the CPU address. The block then reads the word as a type-0 configuration access.

The device select field is one-hot. The block recovers the device number by searching for the lowest set bit in that field. The function and register numbers are taken directly from the word. The result is an enabled configuration address that also carries the current bus number.

A request is rejected and flagged as an error in any of these cases:
- it asks for a type-1 cycle;
- it selects no device;
- it is misaligned for its size.

Every accepted request also pulses a strobe. The status logic uses that strobe to clear its received master-abort and target-abort flags. Issuing the bus cycle itself belongs to another block.

Top module: `cfg_addr_xlate`

## Requirements
- R1: The configuration word is the concatenation {map_reg[15:0], cpu_addr[15:0]}, with map_reg supplying bits 31:16.
- R2: The device number is the index of the lowest set bit among word bits 31:11, where bit 11 is device 0. Higher set bits are ignored.
- R3: The function number is word bits 10:8. The register offset is word bits 7:0 ANDed with 0xFC.
- R4: An accepted address has bit 31 = 1, bits 30:24 = 0, bus_num in bits 23:16, the device in bits 15:11, the function in bits 10:8 and the register offset in bits 7:0.
- R5: When map_reg[16] is 1, the request is a type-1 request. It is rejected: cfg_err is raised and cfg_valid stays low.
- R6: When word bits 31:11 are all zero, the request is rejected with cfg_err.
- R7: req_size encodes the access width: 0 = byte (any alignment), 1 = halfword (requires cpu_addr[0] = 0), 2 = word (requires cpu_addr[1:0] = 0), 3 = reserved. A misaligned request or a reserved size is rejected with cfg_err.
- R8: Each request sampled with req_valid high produces, on the next clock edge, exactly one of cfg_valid or cfg_err. In a cycle with no request, both are low. cfg_addr is zero whenever cfg_valid is low.
- R9: abort_clr pulses in exactly the cycles in which cfg_valid is high, and never with cfg_err.
- R10: While rst_n is low, cfg_valid, cfg_err, abort_clr and cfg_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_size | input | 2 | Access width code (R7) |
| cpu_addr | input | 16 | Low CPU address bits into the window |
| map_reg | input | 17 | Mapping register: bits 15:0 are the upper address, bit 16 is the type-1 flag |
| bus_num | input | 8 | Bus number inserted into the address |
| cfg_addr | output | 32 | Enabled configuration address, or zero when not valid |
| cfg_valid | output | 1 | Accepted translation, one cycle after the request |
| cfg_err | output | 1 | Rejected request, one cycle after the request |
| abort_clr | output | 1 | Strobe that clears the received abort status flags |

## Verification
The assertions assume that map_reg and bus_num hold steady during the cycle in which req_valid is sampled. They also assume that req_size is a defined two-bit value whenever req_valid is high. The bench changes all inputs only at the falling edge and drives every field to a known value before it raises req_valid. Requests with several set select bits, an empty select field, the reserved size and both misalignment cases are therefore deliberate stimuli, not accidents of undriven inputs.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int WORD_W    = 32;
  localparam int LOW_W     = 16;
  localparam int MAP_W     = 17;
  localparam int TYPE1_BIT = 16;
  localparam int SEL_LSB   = 11;
  localparam int SEL_W     = WORD_W - SEL_LSB;
  localparam int DEV_W     = 5;
  localparam int FN_W      = 3;
  localparam int BUS_W     = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Alignment rule per access width
  function automatic logic size_aligned(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: size_aligned = 1'b1;
      SZ_HALF: size_aligned = (lo[0] == 1'b0);
      SZ_WORD: size_aligned = (lo == 2'b00);
      default: size_aligned = 1'b0;
    endcase
  endfunction

  // Assemble the enabled configuration address
  function automatic logic [WORD_W-1:0] pack_cfg(
    input logic [BUS_W-1:0] bus,
    input logic [DEV_W-1:0] dev,
    input logic [FN_W-1:0]  fn,
    input logic [7:0]       regoff
  );
    pack_cfg = {1'b1, 7'd0, bus, dev, fn, regoff & 8'hFC};
  endfunction
endpackage

// File: rtl/cfgx_lsb_find.sv
module cfgx_lsb_find #(
  parameter int W     = 21,
  parameter int OUT_W = 5
) (
  input  logic [W-1:0]     vec,
  output logic [OUT_W-1:0] idx,
  output logic             found
);
  // Scan from the top so the lowest set bit writes last and wins
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = OUT_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
(
  input  logic [LOW_W-1:0]  cpu_lo,
  input  logic [MAP_W-1:0]  map_reg,
  input  logic [1:0]        size,
  input  logic [BUS_W-1:0]  bus,
  output logic [WORD_W-1:0] xl_addr,
  output logic              err_type1,
  output logic              err_nosel,
  output logic              err_align
);
  logic [WORD_W-1:0] cfg_word;
  logic [SEL_W-1:0]  sel_field;
  logic [DEV_W-1:0]  dev_no;
  logic              sel_found;

  assign cfg_word  = {map_reg[LOW_W-1:0], cpu_lo};
  assign sel_field = cfg_word[WORD_W-1:SEL_LSB];

  cfgx_lsb_find #(.W(SEL_W), .OUT_W(DEV_W)) u_find (
    .vec   (sel_field),
    .idx   (dev_no),
    .found (sel_found)
  );

  assign err_type1 = map_reg[TYPE1_BIT];
  assign err_nosel = !sel_found;
  assign err_align = !size_aligned(size, cpu_lo[1:0]);
  assign xl_addr   = pack_cfg(bus, dev_no, cfg_word[10:8], cfg_word[7:0]);
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cfgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_size,
  input  logic [LOW_W-1:0]  cpu_addr,
  input  logic [MAP_W-1:0]  map_reg,
  input  logic [BUS_W-1:0]  bus_num,
  output logic [WORD_W-1:0] cfg_addr,
  output logic              cfg_valid,
  output logic              cfg_err,
  output logic              abort_clr
);
  logic [WORD_W-1:0] xl_addr;
  logic err_type1, err_nosel, err_align;
  logic reject, accept;

  cfgx_decode u_dec (
    .cpu_lo    (cpu_addr),
    .map_reg   (map_reg),
    .size      (req_size),
    .bus       (bus_num),
    .xl_addr   (xl_addr),
    .err_type1 (err_type1),
    .err_nosel (err_nosel),
    .err_align (err_align)
  );

  assign reject = req_valid && (err_type1 || err_nosel || err_align);
  assign accept = req_valid && !reject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_addr  <= '0;
      cfg_valid <= 1'b0;
      cfg_err   <= 1'b0;
      abort_clr <= 1'b0;
    end else begin
      cfg_valid <= accept;
      cfg_err   <= reject;
      abort_clr <= accept;
      cfg_addr  <= accept ? xl_addr : '0;
    end
  end

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (cfg_valid ^ cfg_err));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!cfg_valid && !cfg_err));
  // R8
  addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (cfg_addr == '0));
  // R4
  addr_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (cfg_addr[31] && cfg_addr[30:24] == 7'd0 && cfg_addr[1:0] == 2'b00));
  // R4
  bus_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cfg_addr[23:16] == $past(bus_num)));
  // R5
  type1_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && map_reg[TYPE1_BIT]) |=> (cfg_err && !cfg_valid));
  // R6
  nosel_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && map_reg[LOW_W-1:0] == '0 && cpu_addr[15:11] == '0) |=> cfg_err);
  // R7
  size_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == SZ_RSVD) |=> cfg_err);
  // R9
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_clr == cfg_valid);
  // R9
  strobe_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_clr && cfg_err));
endmodule

// File: tb/tb_cfg_addr_xlate.sv
module tb_cfg_addr_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] cpu_addr = 16'd0;
  logic [16:0] map_reg = 17'd0;
  logic [7:0]  bus_num = 8'd0;
  logic [31:0] cfg_addr;
  logic        cfg_valid, cfg_err, abort_clr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          v;
    logic [31:0] a;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  cfg_addr_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .cpu_addr(cpu_addr), .map_reg(map_reg), .bus_num(bus_num),
    .cfg_addr(cfg_addr), .cfg_valid(cfg_valid), .cfg_err(cfg_err),
    .abort_clr(abort_clr)
  );

  function automatic exp_t model(logic [15:0] ca, logic [16:0] mr, logic [1:0] sz,
                                 logic [7:0] bus, string tag);
    exp_t e;
    logic [31:0] full;
    logic [20:0] sel;
    int dev;
    bit bad;
    full = {mr[15:0], ca};
    sel  = full[31:11];
    bad  = mr[16] || (sz == 2'd3) || (sz == 2'd1 && ca[0]) ||
           (sz == 2'd2 && ca[1:0] != 2'b00) || (sel == 0);
    dev = 0;
    while (sel != 0 && !sel[0]) begin
      sel = sel >> 1;
      dev++;
    end
    e.v   = !bad;
    e.a   = bad ? 32'd0 : (32'h8000_0000 | (32'(bus) << 16) | (32'(dev) << 11) |
            (32'(full[10:8]) << 8) | 32'(full[7:0] & 8'hFC));
    e.tag = tag;
    return e;
  endfunction

  task automatic send(logic [15:0] ca, logic [16:0] mr, logic [1:0] sz,
                      logic [7:0] bus, string tag);
    @(negedge clk);
    req_valid = 1'b1;
    cpu_addr  = ca;
    map_reg   = mr;
    req_size  = sz;
    bus_num   = bus;
    q.push_back(model(ca, mr, sz, bus, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: sample request at the edge, compare a quarter period later
  always @(posedge clk) begin
    bit pend;
    exp_t e;
    if (rst_n && !done) begin
      pend = req_valid;
      #5;
      checks++;
      if (pend) begin
        e = q.pop_front();
        if (cfg_valid !== e.v || cfg_err !== !e.v || abort_clr !== e.v ||
            cfg_addr !== e.a) begin
          errors++;
          $display("FAIL %s: valid=%0b err=%0b clr=%0b addr=%h expected valid=%0b err=%0b clr=%0b addr=%h",
                   e.tag, cfg_valid, cfg_err, abort_clr, cfg_addr, e.v, !e.v, e.v, e.a);
        end
      end else if (cfg_valid !== 1'b0 || cfg_err !== 1'b0 || abort_clr !== 1'b0) begin
        errors++;
        $display("FAIL R8 idle: valid=%0b err=%0b clr=%0b expected 0 0 0",
                 cfg_valid, cfg_err, abort_clr);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    // R10
    if (cfg_valid !== 1'b0 || cfg_err !== 1'b0 || abort_clr !== 1'b0 || cfg_addr !== 32'd0) begin
      errors++;
      $display("FAIL R10 reset: valid=%0b err=%0b clr=%0b addr=%h expected all zero",
               cfg_valid, cfg_err, abort_clr, cfg_addr);
    end
    rst_n = 1'b1;
    idle(2);
    send(16'h0800, 17'h00000, 2'd2, 8'h00, "R1 R4 device 0 base");
    send(16'h0000, 17'h00001, 2'd2, 8'h3A, "R1 R2 upper half from map");
    send(16'h1000, 17'h08004, 2'd2, 8'h12, "R2 lowest set bit wins");
    send(16'h0000, 17'h08000, 2'd0, 8'h7E, "R2 top select bit");
    idle(1);
    send(16'h0FFF, 17'h00000, 2'd0, 8'hFF, "R3 function 7 register masked");
    send(16'h0A54, 17'h00000, 2'd1, 8'h01, "R3 R4 halfword fields");
    send(16'h0800, 17'h10001, 2'd2, 8'h05, "R5 type-1 rejected");
    send(16'h07FC, 17'h00000, 2'd2, 8'h05, "R6 empty select field");
    idle(2);
    send(16'h0801, 17'h00000, 2'd1, 8'h09, "R7 halfword misaligned");
    send(16'h0802, 17'h00000, 2'd2, 8'h09, "R7 word misaligned");
    send(16'h0804, 17'h00000, 2'd2, 8'h09, "R7 word aligned");
    send(16'h0803, 17'h00000, 2'd0, 8'h09, "R7 byte any alignment");
    send(16'h0802, 17'h00000, 2'd1, 8'h09, "R7 halfword aligned");
    send(16'h0800, 17'h00000, 2'd3, 8'h09, "R7 reserved size");
    send(16'h4000, 17'h00200, 2'd2, 8'hA5, "R9 strobe after error");
    idle(4);
    done = 1'b1;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R8 missing results: pending=%0d expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R8 watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule